// File: doc/BRIEF.md
# Thermal Trip Limit Monitor

This block watches three temperature zones (an ambient sensor and two remote diodes) and drives an active-low trip output when a zone has stayed too hot. On every pulse of the monitoring strobe it takes one signed 8-bit sample per zone. It compares each sample with that zone's own trip limit, which is separate from any ordinary interrupt threshold. A zone counts as tripped only when its sample is strictly above the limit on two strobes in a row. A sample equal to the limit breaks the run.

Each trip sets a sticky status bit. Software clears a status bit by writing 1 to it, but the clear only takes effect once that zone's trip condition has ended. A per-zone output-enable mask and a global enable bit decide which status bits may pull the trip output low. A lock input freezes the limit registers. A rising edge on the power-good input wipes the status register. All registers sit behind a plain single-cycle read/write port with a combinational read path.

Top module: `thermal_trip_monitor`

## Requirements
- R1: After reset, every limit register reads 0x7F, the status, control and output-enable registers read 0x00, and trip_n is high.
- R2: The register offsets are: 0 control (only bit 1, the global trip enable, is stored), 1 output enable (bits 2:0), 2 status (bit 0 ambient, bit 1 remote diode 1, bit 2 remote diode 2), and 4, 5, 6 the limits of zones 0, 1 and 2. Zone z takes its sample from temp_in[8z+7:8z]. Unused bits read as 0.
- R3: A zone's status bit sets at the strobe where its sample is strictly above its limit for the second strobe in a row. Samples and limits compare as two's-complement values. A sample equal to or below the limit restarts the run, and temp_in is ignored in cycles without a strobe.
- R4: A set status bit stays set while no clearing write and no power-good rise occurs, even after the temperature falls.
- R5: Writing 1 to a status bit clears it only if the zone's trip event is inactive, that is, its latest two strobed samples were not both above the limit. Writing 0 has no effect.
- R6: While lock is high, writes to the limit registers are ignored.
- R7: trip_n is low exactly when some zone has its status bit and its output-enable bit set and control bit 1 is set.
- R8: A rising edge on pwr_good clears the whole status register. A falling edge has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Power-good level; its rising edge clears status |
| lock | input | 1 | Freezes the limit registers while high |
| sample_stb | input | 1 | Monitoring-cycle strobe, one cycle wide |
| temp_in | input | 24 | Signed samples, zone z in bits 8z+7:8z |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| trip_n | output | 1 | Active-low thermal trip output |

## Verification
A run counter that misses a reset would show up as a status bit that sets after a single hot strobe, or after two hot strobes separated by one at the limit. Either appears on the status read the cycle after the second strobe. If the activity flag is wrong, a write-1 clear succeeds while the zone is still hot, or fails after it has cooled; the very next status read shows it. A wrong combination in the output gating shows on trip_n in the same cycle as the enable or mask write that changes it, with no delay in between.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
   localparam int unsigned OFS_CTRL      = 0;
   localparam int unsigned OFS_OUT_EN    = 1;
   localparam int unsigned OFS_STATUS    = 2;
   localparam int unsigned OFS_LIMIT0    = 4;
   localparam int unsigned CTRL_GEN_BIT  = 1;
   localparam logic [7:0]  LIMIT_RESET   = 8'h7F;
endpackage

// File: rtl/ttm_zone_detect.sv
module ttm_zone_detect #(
   parameter int unsigned TEMP_W     = 8,
   parameter int unsigned PERSIST    = 2,
   parameter bit          SIGNED_CMP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stb,
   input  logic [TEMP_W-1:0] temp,
   input  logic [TEMP_W-1:0] limit,
   output logic              hit,
   output logic              active
);
   localparam int unsigned CW = $clog2(PERSIST + 1);
   localparam logic [CW-1:0] FULL = CW'(PERSIST);
   localparam logic [CW-1:0] ARM  = CW'(PERSIST - 1);

   logic          above;
   logic [CW-1:0] run_q;

   generate
      if (SIGNED_CMP) begin : g_signed
         assign above = $signed(temp) > $signed(limit);
      end else begin : g_unsigned
         assign above = temp > limit;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
      end else if (stb) begin
         if (!above)
            run_q <= '0;
         else if (run_q != FULL)
            run_q <= run_q + 1'b1;
      end
   end

   assign hit    = stb && above && (run_q >= ARM);
   assign active = (run_q == FULL);

   // R3: the run only advances on a strobe
   p_run_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !stb |=> $stable(run_q));
   // R3: a cool sample ends the event
   p_cool_ends_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb && !above) |=> !active);
endmodule

// File: rtl/ttm_limit_regs.sv
module ttm_limit_regs #(
   parameter int unsigned ZONES  = 3,
   parameter int unsigned TEMP_W = 8,
   parameter logic [TEMP_W-1:0] RST_VAL = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    lock,
   input  logic [ZONES-1:0]        wr_sel,
   input  logic [TEMP_W-1:0]       wdata,
   output logic [ZONES*TEMP_W-1:0] limits
);
   generate
      for (genvar z = 0; z < ZONES; z++) begin : g_lim
         logic [TEMP_W-1:0] lim_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lim_q <= RST_VAL;
            else if (wr_sel[z] && !lock)
               lim_q <= wdata;
         end
         assign limits[z*TEMP_W +: TEMP_W] = lim_q;
      end
   endgenerate

   // R6: locked limits never move
   p_locked_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> (limits == $past(limits)));
endmodule

// File: rtl/ttm_status_regs.sv
module ttm_status_regs #(
   parameter int unsigned ZONES = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pg_rise,
   input  logic [ZONES-1:0] set_vec,
   input  logic [ZONES-1:0] active_vec,
   input  logic             clr_wr,
   input  logic [ZONES-1:0] clr_mask,
   output logic [ZONES-1:0] status
);
   logic [ZONES-1:0] st_q;
   logic [ZONES-1:0] st_d;
   logic [ZONES-1:0] clr_ok;

   always_comb begin
      clr_ok = clr_wr ? (clr_mask & ~active_vec & ~set_vec) : '0;
      st_d   = (st_q & ~clr_ok) | set_vec;
      if (pg_rise)
         st_d = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= '0;
      else
         st_q <= st_d;
   end

   assign status = st_q;

   // R4: without a clearing write or power-good rise, bits only accumulate
   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!pg_rise && !clr_wr) |=> ((status & $past(status)) == $past(status)));
   // R5: a set bit of an active zone survives a write of 1
   p_active_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pg_rise |=> ((status & $past(status & active_vec)) == $past(status & active_vec)));
   // R8: power-good rise empties the register
   p_pg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pg_rise |=> (status == '0));
endmodule

// File: rtl/ttm_trip_drive.sv
module ttm_trip_drive #(
   parameter int unsigned ZONES   = 3,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ZONES-1:0] status,
   input  logic [ZONES-1:0] out_en,
   input  logic             gen_en,
   output logic             trip_n
);
   logic [ZONES-1:0] armed;
   logic             trip_now_n;

   assign armed      = status & out_en & {ZONES{gen_en}};
   assign trip_now_n = ~|armed;

   generate
      if (REG_OUT) begin : g_reg
         logic trip_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) trip_q <= 1'b1;
            else        trip_q <= trip_now_n;
         end
         assign trip_n = trip_q;
         p_gate_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en |=> trip_n);
      end else begin : g_comb
         assign trip_n = trip_now_n;
         p_gate_comb_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_en |-> trip_n);
         p_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_en == '0) |-> trip_n);
      end
   endgenerate
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
   import ttm_pkg::*;
#(
   parameter int unsigned ZONES      = 3,
   parameter int unsigned TEMP_W     = 8,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned PERSIST    = 2,
   parameter bit          SIGNED_CMP = 1'b1,
   parameter bit          REG_OUT    = 1'b0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    pwr_good,
   input  logic                    lock,
   input  logic                    sample_stb,
   input  logic [ZONES*TEMP_W-1:0] temp_in,
   input  logic                    reg_wr,
   input  logic [ADDR_W-1:0]       reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   output logic                    trip_n
);
   localparam logic [TEMP_W-1:0] LIM_RST = TEMP_W'(LIMIT_RESET);

   generate
      if (ZONES < 1 || ZONES > DATA_W) begin : g_bad_zones
         $error("ZONES must be 1..DATA_W");
      end
      if (TEMP_W > DATA_W) begin : g_bad_temp
         $error("TEMP_W must not exceed DATA_W");
      end
      if (DATA_W <= CTRL_GEN_BIT) begin : g_bad_data
         $error("DATA_W too narrow for control register");
      end
      if (PERSIST < 1) begin : g_bad_persist
         $error("PERSIST must be at least 1");
      end
      if (OFS_LIMIT0 + ZONES > (1 << ADDR_W)) begin : g_bad_addr
         $error("ADDR_W too narrow for register map");
      end
   endgenerate

   // address decode
   logic             wr_ctrl, wr_oe, wr_stat;
   logic [ZONES-1:0] wr_lim;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL));
   assign wr_oe   = reg_wr && (reg_addr == ADDR_W'(OFS_OUT_EN));
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(OFS_STATUS));

   generate
      for (genvar z = 0; z < ZONES; z++) begin : g_dec
         assign wr_lim[z] = reg_wr && (reg_addr == ADDR_W'(OFS_LIMIT0 + z));
      end
   endgenerate

   // control and output-enable
   logic             gen_en_q;
   logic [ZONES-1:0] oe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en_q <= 1'b0;
         oe_q     <= '0;
      end else begin
         if (wr_ctrl) gen_en_q <= reg_wdata[CTRL_GEN_BIT];
         if (wr_oe)   oe_q     <= reg_wdata[ZONES-1:0];
      end
   end

   // power-good edge
   logic pg_q, pg_rise;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_q <= 1'b0;
      else        pg_q <= pwr_good;
   end
   assign pg_rise = pwr_good && !pg_q;

   // limits
   logic [ZONES*TEMP_W-1:0] limits;

   ttm_limit_regs #(
      .ZONES  (ZONES),
      .TEMP_W (TEMP_W),
      .RST_VAL(LIM_RST)
   ) u_limits (
      .clk   (clk),
      .rst_n (rst_n),
      .lock  (lock),
      .wr_sel(wr_lim),
      .wdata (reg_wdata[TEMP_W-1:0]),
      .limits(limits)
   );

   // per-zone detection
   logic [ZONES-1:0] hit_vec, active_vec;

   generate
      for (genvar z = 0; z < ZONES; z++) begin : g_zone
         ttm_zone_detect #(
            .TEMP_W    (TEMP_W),
            .PERSIST   (PERSIST),
            .SIGNED_CMP(SIGNED_CMP)
         ) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .stb   (sample_stb),
            .temp  (temp_in[z*TEMP_W +: TEMP_W]),
            .limit (limits[z*TEMP_W +: TEMP_W]),
            .hit   (hit_vec[z]),
            .active(active_vec[z])
         );
      end
   endgenerate

   // status
   logic [ZONES-1:0] status;

   ttm_status_regs #(.ZONES(ZONES)) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .pg_rise   (pg_rise),
      .set_vec   (hit_vec),
      .active_vec(active_vec),
      .clr_wr    (wr_stat),
      .clr_mask  (reg_wdata[ZONES-1:0]),
      .status    (status)
   );

   // output
   ttm_trip_drive #(.ZONES(ZONES), .REG_OUT(REG_OUT)) u_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .status(status),
      .out_en(oe_q),
      .gen_en(gen_en_q),
      .trip_n(trip_n)
   );

   // read mux
   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(OFS_CTRL))
         reg_rdata[CTRL_GEN_BIT] = gen_en_q;
      if (reg_addr == ADDR_W'(OFS_OUT_EN))
         reg_rdata[ZONES-1:0] = oe_q;
      if (reg_addr == ADDR_W'(OFS_STATUS))
         reg_rdata[ZONES-1:0] = status;
      for (int z = 0; z < ZONES; z++) begin
         if (reg_addr == ADDR_W'(OFS_LIMIT0 + z))
            reg_rdata[TEMP_W-1:0] = limits[z*TEMP_W +: TEMP_W];
      end
   end

   // R3: a status bit can only rise on a strobe in a zone whose event is active
   generate
      for (genvar z = 0; z < ZONES; z++) begin : g_chk
         p_rise_on_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[z]) |-> (active_vec[z] && $past(sample_stb)));
      end
   endgenerate
endmodule

// File: tb/thermal_trip_monitor_test.sv
module thermal_trip_monitor_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_good = 1'b1;
   logic        lock = 1'b0;
   logic        sample_stb = 1'b0;
   logic [23:0] temp_in = '0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        trip_n;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   thermal_trip_monitor uut (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lock(lock),
      .sample_stb(sample_stb), .temp_in(temp_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trip_n(trip_n)
   );

   // each entry: zone0, zone1, zone2 sample, expected status after the strobe
   localparam logic [26:0] VEC [5] = '{
      {8'hFF, 8'hFC, 8'h64, 3'b000},
      {8'hFF, 8'hFA, 8'h65, 3'b000},
      {8'h29, 8'hFC, 8'h65, 3'b100},
      {8'h29, 8'hFC, 8'h32, 3'b111},
      {8'h28, 8'hFB, 8'h32, 3'b111}
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic strobe(input logic [23:0] t);
      temp_in = t; sample_stb = 1'b1;
      @(negedge clk);
      sample_stb = 1'b0;
   endtask

   initial begin
      #4000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int z = 0; z < 3; z++) begin
         rd(4'(4 + z), d); check("R1 limit", d, 8'h7F);
      end
      rd(4'd2, d); check("R1 status", d, 8'h00);
      rd(4'd0, d); check("R1 control", d, 8'h00);
      rd(4'd1, d); check("R1 out enable", d, 8'h00);
      check("R1 trip_n", {7'd0, trip_n}, 8'h01);

      // R2 reserved control bits
      wr(4'd0, 8'hFD); rd(4'd0, d); check("R2 control bits", d, 8'h00);
      wr(4'd0, 8'h00);

      wr(4'd4, 8'h28); wr(4'd5, 8'hFB); wr(4'd6, 8'h64);
      rd(4'd5, d); check("R2 limit1", d, 8'hFB);

      // R3 vector walk
      for (int i = 0; i < 5; i++) begin
         strobe({VEC[i][26:19], VEC[i][18:11], VEC[i][10:3]} == 24'h0 ? 24'h0 :
                {VEC[i][10:3], VEC[i][18:11], VEC[i][26:19]});
         rd(4'd2, d); check($sformatf("R3 step %0d", i), d, {5'd0, VEC[i][2:0]});
      end
      check("R7 masked trip_n", {7'd0, trip_n}, 8'h01);

      // R5 clear while inactive
      wr(4'd2, 8'hFF); rd(4'd2, d); check("R5 clear inactive", d, 8'h00);

      // R3 no strobe
      temp_in = 24'h7F7F7F;
      repeat (3) @(negedge clk);
      rd(4'd2, d); check("R3 no strobe", d, 8'h00);

      // zone0 127, zone1 -128, zone2 101, twice
      strobe(24'h65807F);
      strobe(24'h65807F);
      rd(4'd2, d); check("R3 signed", d, 8'h05);
      wr(4'd2, 8'h07); rd(4'd2, d); check("R5 active keeps", d, 8'h05);
      wr(4'd2, 8'h00); rd(4'd2, d); check("R5 write zero", d, 8'h05);
      strobe(24'h000000);
      rd(4'd2, d); check("R4 sticky", d, 8'h05);
      wr(4'd2, 8'h01); rd(4'd2, d); check("R5 partial clear", d, 8'h04);

      // R7 gating
      wr(4'd1, 8'h04); check("R7 global off", {7'd0, trip_n}, 8'h01);
      wr(4'd0, 8'h02); check("R7 asserted", {7'd0, trip_n}, 8'h00);
      rd(4'd0, d); check("R2 control read", d, 8'h02);
      wr(4'd1, 8'h01); check("R7 mask other zone", {7'd0, trip_n}, 8'h01);
      wr(4'd1, 8'h04);

      // R6 lock
      lock = 1'b1;
      wr(4'd4, 8'h10); rd(4'd4, d); check("R6 locked", d, 8'h28);
      lock = 1'b0;
      wr(4'd4, 8'h10); rd(4'd4, d); check("R6 unlocked", d, 8'h10);

      // R8 power good
      pwr_good = 1'b0;
      repeat (2) @(negedge clk);
      rd(4'd2, d); check("R8 falling ignored", d, 8'h04);
      pwr_good = 1'b1;
      @(negedge clk);
      rd(4'd2, d); check("R8 rise clears", d, 8'h00);
      check("R8 trip released", {7'd0, trip_n}, 8'h01);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule